// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block owns the status/control word of a floating-point unit. The word holds a rounding-mode selector, a denormal-flush control, and three five-bit groups: sticky-style cause bits, per-operation flag bits and enable bits. Each group covers the same five exception conditions: invalid operation, division by zero, overflow, underflow and inexact.

When the arithmetic datapath finishes an operation, it pulses an update strobe and presents a five-bit raw exception vector. The block rebuilds the flag group from that vector alone and merges the new flags into the cause group. If any cause bit meets its enable bit, it requests a trap with a fixed exception code.

A compare operation only reaches the status word when its result is unordered. Software can load the word at any time, and reserved positions are always masked off. The rounding-mode and flush fields are decoded into two control lines that go back to the datapath.

Top module: `fpstat_ctrl`

## Requirements
- R1: After reset the status word reads 0: round-to-nearest (mode 00), flush off, and all flags, causes and enables clear. Both control outputs and `trap_req` are low, and `trap_code` is 0.
- R2: A software write stores `sw_wdata & 32'h0005_FFFF`. Every bit outside that mask reads as zero.
- R3: `rnd_trunc` is high exactly when bits 1:0 of the status word hold 01, the round-toward-zero encoding. The other three codes keep it low, which means round-to-nearest-even.
- R4: `flush_dnrm` follows bit 18 of the status word.
- R5: An accepted update replaces the flag field (bits 6:2) with `upd_exc`. Exception vector bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid. Flag bits whose exception is absent are cleared.
- R6: An accepted update ORs the new flags into the cause field (bits 16:12, same bit order). The enable field (bits 11:7, same order), the rounding mode and the flush bit are left unchanged.
- R7: `trap_req` pulses high for one cycle, in the cycle after an accepted update strobe, when `upd_exc` is nonzero and the updated cause field ANDed with the enable field is nonzero. It stays low whenever `upd_exc` is zero. While it is high, `trap_code` is 12'h120; otherwise `trap_code` is 0.
- R8: A strobe with `upd_cmp` high and `upd_unord` low leaves the status word unchanged and raises no trap.
- R9: When `sw_we` and `upd_vld` are high in the same cycle, the software write is stored. The update is dropped and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 32 | Software write value |
| upd_vld | input | 1 | Datapath operation-complete strobe |
| upd_cmp | input | 1 | The completing operation is a compare |
| upd_unord | input | 1 | The compare result was unordered |
| upd_exc | input | 5 | Raw exception vector {V,Z,O,U,I} |
| csr_rdata | output | 32 | Current status word |
| rnd_trunc | output | 1 | Datapath rounds toward zero |
| flush_dnrm | output | 1 | Datapath flushes denormals to zero |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Exception code that goes with the trap request |

## Verification
On every cycle the assertions check the following:
- reserved bits read zero;
- a software write lands masked;
- an ordered compare leaves the word untouched;
- an accepted update copies the vector into the flags without clearing any cause bit;
- a trap is preceded by a strobe that carried a nonzero vector and no software write.

Other behaviour can only be shown by the bench's sweeps: the trap decision across all 32 exception vectors against several enable patterns, the accumulation of causes over a long sequence of operations, and the decode of all four rounding codes.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
  localparam int unsigned CSR_W    = 32;
  localparam int unsigned NEXC     = 5;
  localparam int unsigned RM_W     = 2;
  localparam int unsigned RM_LSB   = 0;
  localparam int unsigned FLG_LSB  = 2;
  localparam int unsigned EN_LSB   = 7;
  localparam int unsigned CAU_LSB  = 12;
  localparam int unsigned DNRM_BIT = 18;
  localparam int unsigned CODE_W   = 12;

  localparam logic [RM_W-1:0]   RM_TOZERO = 2'b01;
  localparam logic [CODE_W-1:0] TRAP_CODE = 12'h120;

  localparam logic [CSR_W-1:0] GRP_ONES = CSR_W'((1 << NEXC) - 1);
  localparam logic [CSR_W-1:0] RM_MASK  = CSR_W'((1 << RM_W) - 1) << RM_LSB;
  localparam logic [CSR_W-1:0] FLG_MASK = GRP_ONES << FLG_LSB;
  localparam logic [CSR_W-1:0] EN_MASK  = GRP_ONES << EN_LSB;
  localparam logic [CSR_W-1:0] CAU_MASK = GRP_ONES << CAU_LSB;
  localparam logic [CSR_W-1:0] WR_MASK  = RM_MASK | FLG_MASK | EN_MASK | CAU_MASK
                                        | (CSR_W'(1) << DNRM_BIT);
  localparam int unsigned FLG2CAU = CAU_LSB - FLG_LSB;
endpackage

// File: rtl/fpstat_rst_sync.sv
module fpstat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/fpstat_event.sv
module fpstat_event
  import fpstat_pkg::*;
(
  input  logic             upd_vld,
  input  logic             upd_cmp,
  input  logic             upd_unord,
  input  logic             sw_we,
  input  logic [NEXC-1:0]  upd_exc,
  input  logic [CSR_W-1:0] csr_q,
  output logic             take,
  output logic [CSR_W-1:0] csr_upd,
  output logic             trap_nx
);
  logic [CSR_W-1:0] cleared;
  logic [CSR_W-1:0] with_flags;
  logic [NEXC-1:0]  cause_new;
  logic [NEXC-1:0]  enab;

  always_comb begin
    take       = upd_vld & ~sw_we & (~upd_cmp | upd_unord);
    cleared    = csr_q & ~FLG_MASK;
    with_flags = cleared | (CSR_W'(upd_exc) << FLG_LSB);
    csr_upd    = with_flags | ((with_flags & FLG_MASK) << FLG2CAU);
    cause_new  = csr_upd[CAU_LSB +: NEXC];
    enab       = csr_q[EN_LSB +: NEXC];
    trap_nx    = take & (|upd_exc) & (|(cause_new & enab));
  end
endmodule

// File: rtl/fpstat_ctl_dec.sv
module fpstat_ctl_dec
  import fpstat_pkg::*;
(
  input  logic [RM_W-1:0] rm_field,
  input  logic            dnrm_bit,
  output logic            rnd_trunc,
  output logic            flush_dnrm
);
  always_comb begin
    rnd_trunc  = (rm_field == RM_TOZERO);
    flush_dnrm = dnrm_bit;
  end
endmodule

// File: rtl/fpstat_ctrl.sv
module fpstat_ctrl
  import fpstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [CSR_W-1:0]  sw_wdata,
  input  logic              upd_vld,
  input  logic              upd_cmp,
  input  logic              upd_unord,
  input  logic [NEXC-1:0]   upd_exc,
  output logic [CSR_W-1:0]  csr_rdata,
  output logic              rnd_trunc,
  output logic              flush_dnrm,
  output logic              trap_req,
  output logic [CODE_W-1:0] trap_code
);
  logic             rst_sync_n;
  logic [CSR_W-1:0] csr_q, csr_d, csr_upd;
  logic             csr_en, take, trap_nx, trap_q;

  fpstat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fpstat_event u_evt (
    .upd_vld   (upd_vld),
    .upd_cmp   (upd_cmp),
    .upd_unord (upd_unord),
    .sw_we     (sw_we),
    .upd_exc   (upd_exc),
    .csr_q     (csr_q),
    .take      (take),
    .csr_upd   (csr_upd),
    .trap_nx   (trap_nx)
  );

  always_comb begin
    csr_en = sw_we | take;
    if (sw_we) csr_d = sw_wdata & WR_MASK;
    else       csr_d = csr_upd;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      csr_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      if (csr_en) csr_q <= csr_d;
      trap_q <= trap_nx;
    end
  end

  fpstat_ctl_dec u_dec (
    .rm_field   (csr_q[RM_LSB +: RM_W]),
    .dnrm_bit   (csr_q[DNRM_BIT]),
    .rnd_trunc  (rnd_trunc),
    .flush_dnrm (flush_dnrm)
  );

  assign csr_rdata = csr_q;
  assign trap_req  = trap_q;
  assign trap_code = trap_q ? TRAP_CODE : '0;
endmodule

// File: rtl/fpstat_ctrl_chk.sv
module fpstat_ctrl_chk
  import fpstat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sw_we,
  input logic [CSR_W-1:0]  sw_wdata,
  input logic              upd_vld,
  input logic              upd_cmp,
  input logic              upd_unord,
  input logic [NEXC-1:0]   upd_exc,
  input logic [CSR_W-1:0]  csr_rdata,
  input logic              trap_req,
  input logic [CODE_W-1:0] trap_code
);
  logic acc;
  assign acc = upd_vld && !sw_we && (!upd_cmp || upd_unord);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata & ~WR_MASK) == '0);

  // R2
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> csr_rdata == ($past(sw_wdata) & WR_MASK));

  // R5
  flag_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> csr_rdata[FLG_LSB +: NEXC] == $past(upd_exc));

  // R6
  cause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (csr_rdata[CAU_LSB +: NEXC] & $past(csr_rdata[CAU_LSB +: NEXC]))
            == $past(csr_rdata[CAU_LSB +: NEXC]));

  // R8
  ordered_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && upd_cmp && !upd_unord && !sw_we) |=> $stable(csr_rdata) && !trap_req);

  // R7
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(upd_vld && !sw_we && (upd_exc != '0)));

  // R7
  trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> trap_code == TRAP_CODE);

  // R9
  sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> !trap_req);
endmodule

bind fpstat_ctrl fpstat_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sw_we     (sw_we),
  .sw_wdata  (sw_wdata),
  .upd_vld   (upd_vld),
  .upd_cmp   (upd_cmp),
  .upd_unord (upd_unord),
  .upd_exc   (upd_exc),
  .csr_rdata (csr_rdata),
  .trap_req  (trap_req),
  .trap_code (trap_code)
);

// File: tb/fpstat_ctrl_tb.sv
module fpstat_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic        upd_vld = 1'b0, upd_cmp = 1'b0, upd_unord = 1'b0;
  logic [4:0]  upd_exc = '0;
  logic [31:0] csr_rdata;
  logic        rnd_trunc, flush_dnrm, trap_req;
  logic [11:0] trap_code;

  int tests = 0, fails = 0;
  logic [31:0] exp_csr = '0;
  logic        exp_trap = 1'b0;
  localparam logic [31:0] MASK = 32'h0005_FFFF;

  always #2 clk = ~clk;

  fpstat_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .upd_vld(upd_vld), .upd_cmp(upd_cmp), .upd_unord(upd_unord), .upd_exc(upd_exc),
    .csr_rdata(csr_rdata), .rnd_trunc(rnd_trunc), .flush_dnrm(flush_dnrm),
    .trap_req(trap_req), .trap_code(trap_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_trap(input string req);
    chk(req, {31'd0, trap_req}, {31'd0, exp_trap});
    chk(req, {20'd0, trap_code}, exp_trap ? 32'h120 : 32'h0);
  endtask

  task automatic sw_wr(input logic [31:0] v);
    @(negedge clk); sw_we = 1'b1; sw_wdata = v;
    @(negedge clk); sw_we = 1'b0;
    exp_csr = v & MASK; exp_trap = 1'b0;
  endtask

  task automatic do_op(input logic [4:0] exc, input logic cmp, input logic unord);
    logic [4:0] cau, en;
    @(negedge clk); upd_vld = 1'b1; upd_exc = exc; upd_cmp = cmp; upd_unord = unord;
    @(negedge clk); upd_vld = 1'b0; upd_cmp = 1'b0; upd_unord = 1'b0; upd_exc = '0;
    exp_trap = 1'b0;
    if (!cmp || unord) begin
      exp_csr = (exp_csr & ~32'h7C) | ({27'd0, exc} << 2);
      exp_csr = exp_csr | ({27'd0, exc} << 12);
      cau = exp_csr[16:12]; en = exp_csr[11:7];
      exp_trap = (exc != 0) && ((cau & en) != 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", csr_rdata, 32'h0);
    chk("R1", {30'd0, rnd_trunc, flush_dnrm}, 32'h0);
    check_trap("R1");

    // R2
    sw_wr(32'hFFFF_FFFF);
    chk("R2", csr_rdata, 32'h0005_FFFF);
    sw_wr(32'hAAAA_5555);
    chk("R2", csr_rdata, 32'hAAAA_5555 & MASK);

    // R3, R4
    for (int m = 0; m < 4; m++) begin
      sw_wr(32'(m) | 32'h0004_0000);
      chk("R3", {31'd0, rnd_trunc}, {31'd0, m == 1});
      chk("R4", {31'd0, flush_dnrm}, 32'h1);
    end
    sw_wr(32'h1);
    chk("R4", {31'd0, flush_dnrm}, 32'h0);

    // R5, R6, R7 sweep over enable patterns and all exception vectors
    for (int p = 0; p < 4; p++) begin
      logic [4:0] en;
      en = (p == 0) ? 5'h00 : (p == 1) ? 5'h1F : (p == 2) ? 5'h0A : 5'h10;
      sw_wr({15'd0, 5'd0, en, 5'd0, 2'b01});
      for (int e = 0; e < 32; e++) begin
        do_op(5'(e), 1'b0, 1'b0);
        chk("R5", {27'd0, csr_rdata[6:2]}, {27'd0, 5'(e)});
        chk("R6", csr_rdata, exp_csr);
        check_trap("R7");
        @(negedge clk); exp_trap = 1'b0;
        check_trap("R7");
      end
    end

    // R7: zero vector with pending cause and enable does not trap
    sw_wr({15'd0, 5'h1F, 5'h1F, 5'h00, 2'b00});
    do_op(5'h00, 1'b0, 1'b0);
    chk("R7", {31'd0, trap_req}, 32'h0);
    chk("R5", csr_rdata, 32'h0001_FF80);

    // R8: ordered compare ignored, unordered compare updates
    sw_wr({15'd0, 5'h00, 5'h10, 5'h00, 2'b00});
    do_op(5'h10, 1'b1, 1'b0);
    chk("R8", csr_rdata, exp_csr);
    chk("R8", {31'd0, trap_req}, 32'h0);
    do_op(5'h10, 1'b1, 1'b1);
    chk("R8", csr_rdata, exp_csr);
    check_trap("R8");

    // R9: software write beats a same-cycle update
    sw_wr({15'd0, 5'h00, 5'h1F, 5'h00, 2'b00});
    @(negedge clk);
    sw_we = 1'b1; sw_wdata = 32'h0000_0F81;
    upd_vld = 1'b1; upd_exc = 5'h1F;
    @(negedge clk);
    sw_we = 1'b0; upd_vld = 1'b0; upd_exc = '0;
    chk("R9", csr_rdata, 32'h0000_0F81);
    chk("R9", {31'd0, trap_req}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule